// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether an incoming Ethernet frame is kept. The destination address arrives one byte per cycle, first byte first. At the end of the frame the block also receives the frame length and two error flags. One cycle later it returns a one-cycle verdict, together with a status bit that says whether the destination was an individual or a group address. A set of configuration inputs selects the policy:

- accept broadcast frames;
- accept hashed multicast frames;
- promiscuous mode for individual addresses;
- keep frames that are too short;
- keep frames that carry errors;
- automatic transmitter control.

An individual destination is compared against a programmed six-byte station address. The all-ones address is recognised as broadcast. Any other group address is looked up in a 64-entry hash table, indexed by the upper bits of a CRC-32 run over the six destination bytes. With automatic transmitter control on, two reserved table positions let a remote station switch the local transmitter off or back on.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `outValid` and `outAccept` are 0 and `txEnable` is 1.
- R2: A frame opens when `inValid` and `inFirst` are high together. `frameEnd` on an open frame raises `outValid` for exactly the next cycle and closes the frame. `frameEnd` while no frame is open produces no `outValid`. `outValid` never rises without `frameEnd` in the cycle before.
- R3: The address byte sent first sits in `stationAddr[7:0]`, and the next byte in the next 8 bits up. An all-ones destination is broadcast. It is accepted only when `cfgBcastEn` is 1, and this holds whatever its hash table bit is.
- R4: A destination whose first byte has bit 0 set, and which is not broadcast, is multicast. It is accepted only when `cfgMcastEn` is 1 and its hash table bit is 1. `cfgPromisc` has no effect on it.
- R5: A destination whose first byte has bit 0 clear is accepted when `cfgPromisc` is 1, or when all six bytes equal the station address.
- R6: A frame with `inLen` below 64 is rejected unless `cfgRuntOk` is 1. A length of exactly 64 passes.
- R7: A frame with `inCrcErr` or `inAlignErr` set is rejected unless `cfgKeepErr` is 1.
- R8: `outGroup` is 1 for a complete broadcast or multicast destination and 0 for an individual one, whether or not the frame is accepted.
- R9: The hash index is a CRC-32 over the six destination bytes:
  - polynomial 0x04C11DB7, shift-left form;
  - each byte fed least significant bit first;
  - initial value all ones, no final inversion;
  - the index is CRC bits 31..26.
  
  Table bit n is `hashTable[n]`, so register k holds bits 8k to 8k+7.
- R10: Consider a multicast destination (not broadcast) with `cfgAutoTx` set. `txEnable` drops to 0 when its hash index is 62 and rises to 1 when its index is 63. This happens whatever the accept decision is. Nothing else changes `txEnable`.
- R11: A frame that ends before six address bytes arrived is rejected with `outGroup` 0. Bytes after the sixth do not affect the decision. `inFirst` during an open frame restarts the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBcastEn | input | 1 | Accept broadcast |
| cfgMcastEn | input | 1 | Accept hashed multicast |
| cfgPromisc | input | 1 | Accept every individual address |
| cfgRuntOk | input | 1 | Keep frames shorter than 64 bytes |
| cfgKeepErr | input | 1 | Keep frames with CRC or alignment errors |
| cfgAutoTx | input | 1 | Enable remote transmitter control |
| stationAddr | input | 48 | Station address, first byte in bits 7:0 |
| hashTable | input | 64 | Multicast hash table, bit n = index n |
| inValid | input | 1 | Address byte valid |
| inFirst | input | 1 | Byte is the first of a frame |
| inData | input | 8 | Address byte |
| frameEnd | input | 1 | End-of-frame strobe |
| inLen | input | 16 | Frame length in bytes, valid with frameEnd |
| inCrcErr | input | 1 | CRC error, valid with frameEnd |
| inAlignErr | input | 1 | Alignment error, valid with frameEnd |
| outValid | output | 1 | Verdict strobe |
| outAccept | output | 1 | Frame accepted |
| outGroup | output | 1 | Destination was broadcast or multicast |
| txEnable | output | 1 | Local transmitter enable |

## Verification
The bench builds the block with its defaults: a 6-bit hash index over a 64-entry table, a 64-byte minimum length and a 16-bit length field. These defaults put the reserved indices 62 and 63, and the 63/64 length boundary, within reach. The bench has its own bit-serial CRC model. With it, the bench searches for group addresses that hash to 62 and 63, and it programs the table as either only the address's own bit or every bit except that one, so a wrong index or bit mapping turns the verdict around.

// File: rtl/daf_pkg.sv
package daf_pkg;

  localparam int ADDR_BYTES = 6;
  localparam int IDX_W = $clog2(ADDR_BYTES + 1);
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

  // strobes from control to datapath
  typedef struct packed {
    logic             first;     // first address byte of a frame
    logic             take;      // byte is part of the address
    logic [IDX_W-1:0] idx;       // position of the byte in the address
    logic             addrDone;  // all address bytes collected
    logic             decide;    // frame end on an open frame
  } daf_strobe_t;

  // one byte into the running CRC, least significant bit first
  function automatic logic [31:0] crcStep(input logic [31:0] crcIn, input logic [7:0] data);
    logic [31:0] c;
    logic fb;
    c = crcIn;
    for (int b = 0; b < 8; b++) begin
      fb = c[31] ^ data[b];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/daf_ctrl.sv
module daf_ctrl
  import daf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inFirst,
  input  logic        frameEnd,
  output daf_strobe_t stb
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ADDR_BYTES);

  logic             frameOpen;
  logic [IDX_W-1:0] byteCnt;

  always_comb begin
    stb.first    = inValid & inFirst;
    stb.take     = inValid & (inFirst | (frameOpen & (byteCnt < LAST)));
    stb.idx      = inFirst ? '0 : byteCnt;
    stb.addrDone = (byteCnt == LAST);
    stb.decide   = frameEnd & frameOpen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameOpen <= 1'b0;
      byteCnt   <= '0;
    end else begin
      if (stb.decide) frameOpen <= 1'b0;
      if (stb.first) begin
        frameOpen <= 1'b1;
        byteCnt   <= IDX_W'(1);
      end else if (stb.take) begin
        byteCnt <= byteCnt + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/daf_hash_unit.sv
module daf_hash_unit
  import daf_pkg::*;
#(
  parameter int HASH_W = 6,
  localparam int TBL = 1 << HASH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  daf_strobe_t       stb,
  input  logic [7:0]        inData,
  input  logic [TBL-1:0]    hashTable,
  output logic [HASH_W-1:0] hashIdx,
  output logic              hashHit
);

  logic [31:0] crcReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= CRC_INIT;
    end else if (stb.take) begin
      crcReg <= crcStep(stb.first ? CRC_INIT : crcReg, inData);
    end
  end

  assign hashIdx = crcReg[31 -: HASH_W];
  assign hashHit = hashTable[hashIdx];

endmodule

// File: rtl/daf_addr_dp.sv
module daf_addr_dp
  import daf_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int LEN_W = 16,
  parameter int HASH_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  daf_strobe_t             stb,
  input  logic                    cfgBcastEn,
  input  logic                    cfgMcastEn,
  input  logic                    cfgPromisc,
  input  logic                    cfgRuntOk,
  input  logic                    cfgKeepErr,
  input  logic                    cfgAutoTx,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic [7:0]              inData,
  input  logic [LEN_W-1:0]        inLen,
  input  logic                    inCrcErr,
  input  logic                    inAlignErr,
  input  logic [HASH_W-1:0]       hashIdx,
  input  logic                    hashHit,
  output logic                    outValid,
  output logic                    outAccept,
  output logic                    outGroup,
  output logic                    txEnable
);

  localparam int TBL = 1 << HASH_W;
  localparam int PAD = 1 << IDX_W;
  localparam logic [HASH_W-1:0] IDX_OFF = HASH_W'(TBL - 2);
  localparam logic [HASH_W-1:0] IDX_ON  = HASH_W'(TBL - 1);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);

  logic [ADDR_BYTES-1:0] byteEq;
  logic [PAD-1:0]        eqPad;
  logic physMatch, allOnes, groupBit;
  logic isBcast, isMcast, addrOk, lenOk, errOk, verdict;

  // per-position comparison of the incoming byte with the station address
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_cmp
    assign byteEq[k] = (inData == stationAddr[8*k +: 8]);
  end
  assign eqPad = PAD'(byteEq);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physMatch <= 1'b0;
      allOnes   <= 1'b0;
      groupBit  <= 1'b0;
    end else if (stb.take) begin
      physMatch <= (stb.first | physMatch) & eqPad[stb.idx];
      allOnes   <= (stb.first | allOnes) & (inData == 8'hFF);
      if (stb.first) groupBit <= inData[0];
    end
  end

  always_comb begin
    isBcast = allOnes;
    isMcast = groupBit & ~allOnes;
    if (isBcast)      addrOk = cfgBcastEn;
    else if (isMcast) addrOk = cfgMcastEn & hashHit;
    else              addrOk = cfgPromisc | physMatch;
    lenOk   = cfgRuntOk | (inLen >= LEN_MIN);
    errOk   = cfgKeepErr | ~(inCrcErr | inAlignErr);
    verdict = stb.addrDone & addrOk & lenOk & errOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outAccept <= 1'b0;
      outGroup  <= 1'b0;
      txEnable  <= 1'b1;
    end else begin
      outValid <= stb.decide;
      if (stb.decide) begin
        outAccept <= verdict;
        outGroup  <= stb.addrDone & groupBit;
        if (cfgAutoTx & stb.addrDone & isMcast) begin
          if (hashIdx == IDX_OFF)     txEnable <= 1'b0;
          else if (hashIdx == IDX_ON) txEnable <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int LEN_W = 16,
  parameter int HASH_W = 6,
  localparam int TBL = 1 << HASH_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgBcastEn,
  input  logic                    cfgMcastEn,
  input  logic                    cfgPromisc,
  input  logic                    cfgRuntOk,
  input  logic                    cfgKeepErr,
  input  logic                    cfgAutoTx,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic [TBL-1:0]          hashTable,
  input  logic                    inValid,
  input  logic                    inFirst,
  input  logic [7:0]              inData,
  input  logic                    frameEnd,
  input  logic [LEN_W-1:0]        inLen,
  input  logic                    inCrcErr,
  input  logic                    inAlignErr,
  output logic                    outValid,
  output logic                    outAccept,
  output logic                    outGroup,
  output logic                    txEnable
);

  daf_strobe_t       stb;
  logic [HASH_W-1:0] hashIdx;
  logic              hashHit;

  daf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst),
    .frameEnd(frameEnd), .stb(stb)
  );

  daf_hash_unit #(.HASH_W(HASH_W)) u_hash (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .hashTable(hashTable), .hashIdx(hashIdx), .hashHit(hashHit)
  );

  daf_addr_dp #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W), .HASH_W(HASH_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgBcastEn(cfgBcastEn), .cfgMcastEn(cfgMcastEn), .cfgPromisc(cfgPromisc),
    .cfgRuntOk(cfgRuntOk), .cfgKeepErr(cfgKeepErr), .cfgAutoTx(cfgAutoTx),
    .stationAddr(stationAddr), .inData(inData), .inLen(inLen),
    .inCrcErr(inCrcErr), .inAlignErr(inAlignErr),
    .hashIdx(hashIdx), .hashHit(hashHit),
    .outValid(outValid), .outAccept(outAccept), .outGroup(outGroup),
    .txEnable(txEnable)
  );

endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
  parameter int MIN_LEN = 64,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inFirst,
  input logic             frameEnd,
  input logic [LEN_W-1:0] inLen,
  input logic             inCrcErr,
  input logic             inAlignErr,
  input logic             cfgRuntOk,
  input logic             cfgKeepErr,
  input logic             cfgAutoTx,
  input logic             outValid,
  input logic             outAccept,
  input logic             txEnable
);

  logic openSeen;

  always_ff @(posedge clk) begin
    if (!rstN) openSeen <= 1'b0;
    else if (inValid && inFirst) openSeen <= 1'b1;
    else if (frameEnd) openSeen <= 1'b0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (txEnable && !outValid && !outAccept));

  // R2
  verdict_follows_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && openSeen) |=> outValid);

  // R2
  verdict_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(frameEnd));

  // R6
  runt_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && (inLen < LEN_W'(MIN_LEN)) && !cfgRuntOk) |=> (!outValid || !outAccept));

  // R7
  error_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && (inCrcErr || inAlignErr) && !cfgKeepErr) |=> (!outValid || !outAccept));

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(frameEnd && cfgAutoTx) |=> $stable(txEnable));

endmodule

bind dest_addr_filter daf_checker #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst),
  .frameEnd(frameEnd), .inLen(inLen), .inCrcErr(inCrcErr), .inAlignErr(inAlignErr),
  .cfgRuntOk(cfgRuntOk), .cfgKeepErr(cfgKeepErr), .cfgAutoTx(cfgAutoTx),
  .outValid(outValid), .outAccept(outAccept), .txEnable(txEnable)
);

// File: tb/sim_dest_addr_filter.sv
`timescale 1ns/1ps
module sim_dest_addr_filter;

  localparam logic [47:0] STA  = 48'h554433221102;
  localparam logic [47:0] MISS = 48'h564433221102;
  localparam logic [47:0] BC   = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] MC   = 48'h0100005E0001;

  // cfg bits: 0 bcast, 1 mcast, 2 promisc, 3 runt ok, 4 keep errors, 5 auto tx
  typedef struct packed {
    logic [23:0] tag;
    logic [5:0]  cfg;
    logic [47:0] addr;
    logic [15:0] len;
    logic        crcE;
    logic        alnE;
    logic [3:0]  nb;
    logic        hashMode;  // 0: only own bit set, 1: all bits except own
    logic        expAcc;
    logic        expGrp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{"R5 ", 6'b000000, STA,  16'd100, 1'b0, 1'b0, 4'd6, 1'b0, 1'b1, 1'b0},
    '{"R5 ", 6'b000000, MISS, 16'd100, 1'b0, 1'b0, 4'd6, 1'b0, 1'b0, 1'b0},
    '{"R5 ", 6'b000100, MISS, 16'd100, 1'b0, 1'b0, 4'd6, 1'b0, 1'b1, 1'b0},
    '{"R3 ", 6'b000000, BC,   16'd100, 1'b0, 1'b0, 4'd6, 1'b0, 1'b0, 1'b1},
    '{"R3 ", 6'b000001, BC,   16'd100, 1'b0, 1'b0, 4'd6, 1'b0, 1'b1, 1'b1},
    '{"R3 ", 6'b000010, BC,   16'd100, 1'b0, 1'b0, 4'd6, 1'b0, 1'b0, 1'b1},
    '{"R4 ", 6'b000010, MC,   16'd100, 1'b0, 1'b0, 4'd6, 1'b0, 1'b1, 1'b1},
    '{"R9 ", 6'b000010, MC,   16'd100, 1'b0, 1'b0, 4'd6, 1'b1, 1'b0, 1'b1},
    '{"R4 ", 6'b000000, MC,   16'd100, 1'b0, 1'b0, 4'd6, 1'b0, 1'b0, 1'b1},
    '{"R4 ", 6'b000100, MC,   16'd100, 1'b0, 1'b0, 4'd6, 1'b0, 1'b0, 1'b1},
    '{"R6 ", 6'b000000, STA,  16'd63,  1'b0, 1'b0, 4'd6, 1'b0, 1'b0, 1'b0},
    '{"R6 ", 6'b001000, STA,  16'd63,  1'b0, 1'b0, 4'd6, 1'b0, 1'b1, 1'b0},
    '{"R6 ", 6'b000000, STA,  16'd64,  1'b0, 1'b0, 4'd6, 1'b0, 1'b1, 1'b0},
    '{"R7 ", 6'b000000, STA,  16'd100, 1'b1, 1'b0, 4'd6, 1'b0, 1'b0, 1'b0},
    '{"R7 ", 6'b000000, STA,  16'd100, 1'b0, 1'b1, 4'd6, 1'b0, 1'b0, 1'b0},
    '{"R7 ", 6'b010000, STA,  16'd100, 1'b1, 1'b1, 4'd6, 1'b0, 1'b1, 1'b0},
    '{"R11", 6'b000000, STA,  16'd100, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0},
    '{"R11", 6'b000000, STA,  16'd100, 1'b0, 1'b0, 4'd8, 1'b0, 1'b1, 1'b0},
    '{"R11", 6'b000000, MISS, 16'd100, 1'b0, 1'b0, 4'd8, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] cfg = '0;
  logic [63:0] hashTable = '0;
  logic inValid = 1'b0, inFirst = 1'b0, frameEnd = 1'b0;
  logic [7:0] inData = '0;
  logic [15:0] inLen = '0;
  logic inCrcErr = 1'b0, inAlignErr = 1'b0;
  logic outValid, outAccept, outGroup, txEnable;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dest_addr_filter u0 (
    .clk(clk), .rstN(rstN),
    .cfgBcastEn(cfg[0]), .cfgMcastEn(cfg[1]), .cfgPromisc(cfg[2]),
    .cfgRuntOk(cfg[3]), .cfgKeepErr(cfg[4]), .cfgAutoTx(cfg[5]),
    .stationAddr(STA), .hashTable(hashTable),
    .inValid(inValid), .inFirst(inFirst), .inData(inData),
    .frameEnd(frameEnd), .inLen(inLen), .inCrcErr(inCrcErr), .inAlignErr(inAlignErr),
    .outValid(outValid), .outAccept(outAccept), .outGroup(outGroup), .txEnable(txEnable)
  );

  // bit-serial reference of the hash index over the 48 address bits in wire order
  function automatic logic [5:0] refIdx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = c[31] ^ a[i];
      c = c << 1;
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c[31:26];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drives bytes on negative edges, ends the frame, then waits until the verdict is visible
  task automatic sendFrame(input logic [47:0] a, input int nb, input logic [15:0] len,
                           input logic ce, input logic ae);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inFirst = (i == 0);
      inData  = (i < 6) ? a[8*i +: 8] : 8'hAA;
    end
    @(negedge clk);
    inValid = 1'b0; inFirst = 1'b0;
    frameEnd = 1'b1; inLen = len; inCrcErr = ce; inAlignErr = ae;
    @(negedge clk);
    frameEnd = 1'b0; inCrcErr = 1'b0; inAlignErr = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [47:0] a62, a63;
    bit f62, f63;
    f62 = 1'b0; f63 = 1'b0; a62 = '0; a63 = '0;
    for (int i = 0; i < 4096; i++) begin
      logic [47:0] cand;
      cand = {8'(i >> 8), 8'(i), 8'h00, 8'h5E, 8'h00, 8'h01};
      if (!f62 && refIdx(cand) == 6'd62) begin a62 = cand; f62 = 1'b1; end
      if (!f63 && refIdx(cand) == 6'd63) begin a63 = cand; f63 = 1'b1; end
    end

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 64'(outValid), 64'd0);
    check("R1 accept", 64'(outAccept), 64'd0);
    check("R1 txEnable", 64'(txEnable), 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 txEnable after release", 64'(txEnable), 64'd1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [5:0] ix;
      ix = refIdx(VECS[v].addr);
      cfg = VECS[v].cfg;
      hashTable = VECS[v].hashMode ? ~(64'd1 << ix) : (64'd1 << ix);
      sendFrame(VECS[v].addr, int'(VECS[v].nb), VECS[v].len, VECS[v].crcE, VECS[v].alnE);
      check({"R2 valid vec ", $sformatf("%0d", v)}, 64'(outValid), 64'd1);
      check({$sformatf("%s accept vec %0d", VECS[v].tag, v)}, 64'(outAccept), 64'(VECS[v].expAcc));
      check({$sformatf("R8 group vec %0d", v)}, 64'(outGroup), 64'(VECS[v].expGrp));
      @(negedge clk);
      check("R2 valid is one cycle", 64'(outValid), 64'd0);
    end

    // R2 frame end with no open frame
    @(negedge clk);
    frameEnd = 1'b1; inLen = 16'd100;
    @(negedge clk);
    frameEnd = 1'b0;
    check("R2 stray end gives no verdict", 64'(outValid), 64'd0);

    // R11 restart with inFirst in the middle of an address
    cfg = 6'b000000;
    @(negedge clk); inValid = 1'b1; inFirst = 1'b1; inData = MISS[7:0];
    @(negedge clk); inFirst = 1'b0; inData = 8'h00;
    @(negedge clk); inData = 8'h00;
    sendFrame(STA, 6, 16'd100, 1'b0, 1'b0);
    check("R11 restart valid", 64'(outValid), 64'd1);
    check("R11 restart accept", 64'(outAccept), 64'd1);

    // R10 remote transmitter control
    check("R10 search 62", 64'(f62), 64'd1);
    check("R10 search 63", 64'(f63), 64'd1);
    hashTable = '0;
    cfg = 6'b100000;
    sendFrame(a62, 6, 16'd100, 1'b0, 1'b0);
    check("R10 index 62 disables", 64'(txEnable), 64'd0);
    check("R10 not accepted", 64'(outAccept), 64'd0);
    sendFrame(BC, 6, 16'd100, 1'b0, 1'b0);
    check("R10 broadcast no effect", 64'(txEnable), 64'd0);
    sendFrame(MC, 6, 16'd100, 1'b0, 1'b0);
    check("R10 other index no effect", 64'(txEnable),
          (refIdx(MC) == 6'd63) ? 64'd1 : 64'd0);
    sendFrame(a63, 6, 16'd100, 1'b0, 1'b0);
    check("R10 index 63 enables", 64'(txEnable), 64'd1);
    cfg = 6'b000000;
    sendFrame(a62, 6, 16'd100, 1'b0, 1'b0);
    check("R10 auto off keeps enable", 64'(txEnable), 64'd1);
    cfg = 6'b100000;
    sendFrame(a62, 4, 16'd100, 1'b0, 1'b0);
    check("R10 short address no effect", 64'(txEnable), 64'd1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule